// File: doc/BRIEF.md
# Masked Address Bus Break Unit

This block is a debug watchpoint. It watches one bus cycle per clock on a processor-side bus. When a valid cycle matches a programmed condition, it raises a break interrupt request. The condition has three parts, and all of them must agree:

- a 32-bit break address, compared under a per-bit mask;
- a bus-master qualifier, which selects the processor, the DMA/transfer controller, or both;
- an access-type qualifier, which selects instruction fetches, data accesses, or both.

Software sets the condition through a small synchronous 16-bit register port. The request is sticky: it stays high until software clears it through a status register. It is meant to feed an interrupt controller, which then enters the debug handler.

Register offsets on `reg_addr`:

| Offset | Contents |
|--------|----------|
| 0 | Break address, upper half (bits 31:16) |
| 1 | Break address, lower half (bits 15:0) |
| 2 | Mask, upper half (bits 31:16) |
| 3 | Mask, lower half (bits 15:0) |
| 4 | Condition register |
| 5 | Status register |
| 6, 7 | Unmapped |

Top module: `addr_break_unit`

## Requirements
- R1: After reset, the break address, mask and condition registers all read 0, and `brk_req` is low, so every address bit takes part in the comparison.
- R2: An address bit takes part in the comparison only when its mask bit is 0. When its mask bit is 1, a difference in that bit does not prevent a match.
- R3: A cycle matches only when `mon_valid` is high, the address agrees, and both qualifiers accept the cycle. `brk_req` rises on the clock edge after the matching cycle. An unmatched cycle, or a cycle with `mon_valid` low, does not raise it.
- R4: Condition bits 7:6 select the master. The encodings are 00 = never, 01 = processor only (`mon_dma`=0), 10 = DMA/transfer controller only (`mon_dma`=1), 11 = either master.
- R5: Condition bits 5:4 select the access type. The encodings are 00 = never, 01 = instruction fetch only (`mon_data`=0), 10 = data access only (`mon_data`=1), 11 = either access type.
- R6: Once set, `brk_req` stays high through idle cycles, and through status writes whose bit 0 is 0.
- R7: A status write (offset 5) with bit 0 set clears `brk_req` on that edge. If a matching cycle arrives in the same cycle, the request stays set. Status bit 0 reads back the current request.
- R8: Condition-register bits 15:8 and 3:0 read 0 and ignore written values. Unmapped offsets 6 and 7 read 0.
- R9: The break address and mask are written and read back as 16-bit halves at the offsets listed above (0 upper address, 1 lower address, 2 upper mask, 3 lower mask). `reg_rdata` shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mon_valid | input | 1 | Observed bus cycle is valid |
| mon_addr | input | 32 | Observed bus address |
| mon_dma | input | 1 | 1 = DMA/transfer-controller cycle, 0 = processor cycle |
| mon_data | input | 1 | 1 = data access, 0 = instruction fetch |
| brk_req | output | 1 | Sticky break interrupt request |

## Verification
The bench tries all sixteen qualifier settings. For each setting it applies four cycle kinds: processor fetch, processor data, DMA fetch and DMA data. This exposes a swapped field, a swapped encoding or a missing 00-disable in either qualifier. Address matching is tested with single-bit differences in three cases: a difference in an unmasked bit, the same difference with that bit masked, and a difference in a different bit while only the first bit is masked. These cases separate a correct per-bit mask from an inverted or global mask. Separate tests cover the sticky behaviour, the clear, a match arriving during a clear, and reserved-bit readback.

// File: rtl/addr_break_unit.sv
module addr_break_unit #(
  parameter int RW   = 16,
  parameter int OFFW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OFFW-1:0] reg_addr,
  input  logic            reg_we,
  input  logic [RW-1:0]   reg_wdata,
  output logic [RW-1:0]   reg_rdata,
  input  logic            mon_valid,
  input  logic [2*RW-1:0] mon_addr,
  input  logic            mon_dma,
  input  logic            mon_data,
  output logic            brk_req
);
  localparam int AW = 2 * RW;
  localparam logic [OFFW-1:0] OFF_AH = 0, OFF_AL = 1, OFF_MH = 2, OFF_ML = 3,
                              OFF_CND = 4, OFF_STA = 5;

  logic [AW-1:0] brk_addr, brk_mask;
  logic [1:0]    cond_master, cond_type;
  logic          brk_q;

  wire wr_clr    = reg_we && reg_addr == OFF_STA && reg_wdata[0];
  wire master_ok = mon_dma  ? cond_master[1] : cond_master[0];
  wire type_ok   = mon_data ? cond_type[1]   : cond_type[0];
  wire addr_ok   = ((mon_addr ^ brk_addr) & ~brk_mask) == '0;
  wire hit       = mon_valid && addr_ok && master_ok && type_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_addr    <= '0;
      brk_mask    <= '0;
      cond_master <= '0;
      cond_type   <= '0;
      brk_q       <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          OFF_AH:  brk_addr[AW-1:RW] <= reg_wdata;
          OFF_AL:  brk_addr[RW-1:0]  <= reg_wdata;
          OFF_MH:  brk_mask[AW-1:RW] <= reg_wdata;
          OFF_ML:  brk_mask[RW-1:0]  <= reg_wdata;
          OFF_CND: {cond_master, cond_type} <= reg_wdata[7:4];
          default: ;
        endcase
      end
      brk_q <= hit || (brk_q && !wr_clr);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_AH:  reg_rdata = brk_addr[AW-1:RW];
      OFF_AL:  reg_rdata = brk_addr[RW-1:0];
      OFF_MH:  reg_rdata = brk_mask[AW-1:RW];
      OFF_ML:  reg_rdata = brk_mask[RW-1:0];
      OFF_CND: reg_rdata[7:4] = {cond_master, cond_type};
      OFF_STA: reg_rdata[0] = brk_q;
      default: ;
    endcase
  end

  assign brk_req = brk_q;
endmodule

// File: rtl/addr_break_unit_chk.sv
module addr_break_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  reg_addr,
  input logic        reg_we,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        mon_valid,
  input logic [31:0] mon_addr,
  input logic        mon_dma,
  input logic        mon_data,
  input logic        brk_req,
  input logic [31:0] brk_addr,
  input logic [31:0] brk_mask,
  input logic [1:0]  cond_master,
  input logic [1:0]  cond_type
);
  wire clr_wr = reg_we && reg_addr == 3'd5 && reg_wdata[0];

  a_r2_masked_match: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_valid && (((mon_addr ^ brk_addr) & ~brk_mask) == 32'd0)
     && cond_master[mon_dma] && cond_type[mon_data]) |=> brk_req);

  a_r4_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_master == 2'b00 && !brk_req) |=> !brk_req);

  a_r5_type_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_type == 2'b00 && !brk_req) |=> !brk_req);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !clr_wr) |=> brk_req);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !mon_valid) |=> !brk_req);

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd4) |-> (reg_rdata[15:8] == 8'd0 && reg_rdata[3:0] == 4'd0));
endmodule

bind addr_break_unit addr_break_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_valid(mon_valid),
  .mon_addr(mon_addr), .mon_dma(mon_dma), .mon_data(mon_data),
  .brk_req(brk_req), .brk_addr(brk_addr), .brk_mask(brk_mask),
  .cond_master(cond_master), .cond_type(cond_type)
);

// File: tb/addr_break_unit_bench.sv
module addr_break_unit_bench;
  localparam int CLK_PERIOD = 10;

  // {master[1:0], type[1:0], hits for cpu-fetch, cpu-data, dma-fetch, dma-data in bits 0..3}
  localparam logic [7:0] VEC [16] = '{
    8'h00, 8'h10, 8'h20, 8'h30,
    8'h40, 8'h51, 8'h62, 8'h73,
    8'h80, 8'h94, 8'hA8, 8'hBC,
    8'hC0, 8'hD5, 8'hEA, 8'hFF
  };

  logic        clk = 0, rst_n = 0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mon_valid = 0;
  logic [31:0] mon_addr = '0;
  logic        mon_dma = 0, mon_data = 0;
  logic        brk_req;
  int n_chk = 0, n_fail = 0;

  addr_break_unit u_addr_break_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_valid(mon_valid),
    .mon_addr(mon_addr), .mon_dma(mon_dma), .mon_data(mon_data), .brk_req(brk_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_check(string req, logic [2:0] a, logic [15:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic bus(logic v, logic [31:0] a, logic dma, logic dat);
    @(negedge clk);
    mon_valid = v; mon_addr = a; mon_dma = dma; mon_data = dat;
    @(negedge clk);
    mon_valid = 0;
  endtask

  task automatic clr();
    wr(3'd5, 16'h0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 brk_req", brk_req, 0);
    for (int i = 0; i < 5; i++) rd_check("R1 regs", 3'(i), 16'h0000);
    rst_n = 1;

    // R9: readback of halves
    wr(3'd0, 16'hCAFE); wr(3'd1, 16'h0BAD);
    rd_check("R9 addr hi", 3'd0, 16'hCAFE);
    rd_check("R9 addr lo", 3'd1, 16'h0BAD);
    wr(3'd2, 16'h8001); wr(3'd3, 16'h0100);
    rd_check("R9 mask hi", 3'd2, 16'h8001);
    rd_check("R9 mask lo", 3'd3, 16'h0100);
    wr(3'd2, 16'h0000); wr(3'd3, 16'h0000);

    // R8: reserved bits and unmapped offsets
    wr(3'd4, 16'hFFFF);
    rd_check("R8 cond reserved", 3'd4, 16'h00F0);
    rd_check("R8 unmapped 6", 3'd6, 16'h0000);
    rd_check("R8 unmapped 7", 3'd7, 16'h0000);

    // R4/R5: qualifier sweep
    for (int v = 0; v < 16; v++) begin
      wr(3'd4, {8'h00, VEC[v][7:4], 4'h0});
      for (int k = 0; k < 4; k++) begin
        clr();
        bus(1, 32'hCAFE0BAD, k[1], k[0]);
        check($sformatf("R4/R5 qual=%h kind=%0d", VEC[v][7:4], k), brk_req, VEC[v][k]);
      end
    end

    // R3: invalid cycle and mismatching address ignored
    wr(3'd4, 16'h00F0); clr();
    bus(0, 32'hCAFE0BAD, 0, 0);
    check("R3 invalid cycle", brk_req, 0);
    bus(1, 32'hCAFE0BAC, 0, 0);
    check("R3 addr mismatch", brk_req, 0);

    // R2: mask
    wr(3'd3, 16'h0001);
    bus(1, 32'hCAFE0BAC, 0, 0);
    check("R2 masked bit0 differs", brk_req, 1);
    clr();
    bus(1, 32'h4AFE0BAD, 1, 1);
    check("R2 unmasked bit31 differs", brk_req, 0);
    wr(3'd2, 16'h8000);
    bus(1, 32'h4AFE0BAC, 1, 1);
    check("R2 both masked", brk_req, 1);

    // R6: sticky
    repeat (4) @(negedge clk);
    check("R6 sticky idle", brk_req, 1);
    wr(3'd5, 16'h0000);
    check("R6 write 0 keeps", brk_req, 1);
    rd_check("R7 status reads 1", 3'd5, 16'h0001);

    // R7: clear, and match during clear
    clr();
    check("R7 cleared", brk_req, 0);
    rd_check("R7 status reads 0", 3'd5, 16'h0000);
    bus(1, 32'hCAFE0BAD, 0, 0);
    @(negedge clk);
    reg_addr = 3'd5; reg_we = 1; reg_wdata = 16'h0001;
    mon_valid = 1; mon_addr = 32'hCAFE0BAD;
    @(negedge clk);
    reg_we = 0; mon_valid = 0;
    check("R7 match wins over clear", brk_req, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule